// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a synchronous host and an external byte-wide static memory that has no clock. The host presents one request at a time: a direction bit, a word address, and a write byte. The controller turns that request into a timed sequence on the memory's shared address bus, its data lines and three active-low strobes: chip select, write enable and output enable. Every interval in that sequence is a parameter counted in system clock cycles. Each default is rounded up from the memory's nanosecond minimum at a 100 MHz clock.

A write works as follows. The controller places the address and lowers select while both the write and output strobes stay high. It then lowers write enable and drives the byte for the whole pulse. Next it raises write enable while address, data and select stay in place for the hold interval, and only then releases everything.

A read works as follows. The controller lowers select and waits until its own data driver has been off for the turnaround interval. It then holds output enable low for the access interval and captures the bus on the last access cycle. The byte is returned with a one-cycle valid flag. The data bus is split into an output value, a driver enable and an input value, so that the pad ring can build the tri-state buffer.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and after reset, with no request, select, write enable and output enable are high, the data driver is off, and busy and rdata_valid are low.
- R2: A request is taken only on a clock edge where busy is low. Busy is high from the next cycle until the operation ends. A request raised while busy is high has no effect on memory contents. An isolated write keeps busy high for SETUP_CYC+PULSE_CYC+HOLD_CYC cycles. An isolated read keeps busy high for 1+ACCESS_CYC cycles.
- R3: In a write, select is low with the address applied for at least SETUP_CYC cycles before write enable falls. Write enable stays low for exactly PULSE_CYC cycles. Output enable stays high throughout.
- R4: The write byte is driven in every cycle that write enable is low. After write enable rises, data, address and select stay unchanged for HOLD_CYC further cycles.
- R5: In a read, write enable stays high and output enable is low for exactly ACCESS_CYC cycles. rdata carries the memory byte present on the last of those cycles.
- R6: rdata_valid is high for exactly one cycle per read, in the first cycle that busy is low again.
- R7: The data driver and output enable are never active in the same cycle. Output enable falls only after the driver has been off for at least TURN_CYC cycles. The driver turns on only after output enable has been high for at least TURN_CYC cycles.
- R8: Whenever busy is low or select is high, write enable and output enable are high and the driver is off.
- R9: The address does not change in any two consecutive cycles during which select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, taken when busy is low |
| req_we | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Byte to be written |
| busy | output | 1 | An operation is in progress |
| rdata | output | DATA_W | Byte captured by the last read |
| rdata_valid | output | 1 | One-cycle flag that rdata is new |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | DATA_W | Value for the data pads |
| mem_dq_oe | output | 1 | Data pad driver enable, active high |
| mem_dq_in | input | DATA_W | Value seen on the data pads |

## Verification
The assertions check on every cycle the properties of the strobe pins: write enable only under select, no overlap of driver and output enable, data present across the whole write pulse and hold, a still address while select is low, the one-cycle valid flag, and the turnaround guard at the falling edge of output enable. The exact widths of the pulse and access windows, and the fact that written bytes come back at the right address, can only be shown by the bench's scenarios. There, a timing-aware memory model returns garbage when output enable is held too briefly and stores bytes only at the rising edge of write enable. The same holds for turnaround after back-to-back operations and for requests raised while busy being dropped.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WR_SETUP,
        PH_WR_PULSE,
        PH_WR_HOLD,
        PH_RD_WAIT,
        PH_RD_ACCESS
    } phase_e;

    typedef struct packed {
        logic sel_n;
        logic we_n;
        logic oe_n;
        logic drv;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{sel_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

endpackage

// File: rtl/phase_strobe_map.sv
module phase_strobe_map
    import sram_ctrl_pkg::*;
(
    input  phase_e  phase,
    output strobe_t strb
);

    always_comb begin
        strb = STROBE_IDLE;
        unique case (phase)
            PH_IDLE:      strb = STROBE_IDLE;
            PH_WR_SETUP:  strb = '{sel_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
            PH_WR_PULSE:  strb = '{sel_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drv: 1'b1};
            PH_WR_HOLD:   strb = '{sel_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
            PH_RD_WAIT:   strb = '{sel_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
            PH_RD_ACCESS: strb = '{sel_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drv: 1'b0};
            default:      strb = STROBE_IDLE;
        endcase
    end

endmodule

// File: rtl/bus_quiet_counter.sv
module bus_quiet_counter #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic quiet
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (active) begin
            cnt_d = '0;
        end else if (cnt_q != TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= TOP;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign quiet = (cnt_q == TOP);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 7,
    parameter int HOLD_CYC   = 1,
    parameter int ACCESS_CYC = 7,
    parameter int TURN_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    localparam int MAX_CYC = max4(SETUP_CYC, PULSE_CYC, HOLD_CYC, ACCESS_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(ACCESS_CYC - 1);
    localparam int LANES = 2;   // lane 0: data driver, lane 1: output enable

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } core_t;

    core_t   core_d, core_q;
    strobe_t strb_d, strb_q;
    logic [LANES-1:0] lane_active, lane_quiet;

    // Idle-time tracking for bus turnaround, one counter per lane
    assign lane_active[0] = strb_q.drv;
    assign lane_active[1] = !strb_q.oe_n;

    for (genvar g = 0; g < LANES; g++) begin : g_quiet
        bus_quiet_counter #(.LIMIT(TURN_CYC)) u_quiet (
            .clk    (clk),
            .rst    (rst),
            .active (lane_active[g]),
            .quiet  (lane_quiet[g])
        );
    end

    // Sequencer: every next value of the core state
    always_comb begin
        core_d        = core_q;
        core_d.rvalid = 1'b0;
        unique case (core_q.phase)
            PH_IDLE: begin
                if (req) begin
                    core_d.addr  = req_addr;
                    core_d.wdata = req_wdata;
                    if (req_we) begin
                        core_d.phase = PH_WR_SETUP;
                        core_d.cnt   = LD_SETUP;
                    end else begin
                        core_d.phase = PH_RD_WAIT;
                        core_d.cnt   = '0;
                    end
                end
            end
            PH_WR_SETUP: begin
                if (core_q.cnt != '0) begin
                    core_d.cnt = core_q.cnt - 1'b1;
                end else if (lane_quiet[1]) begin
                    core_d.phase = PH_WR_PULSE;
                    core_d.cnt   = LD_PULSE;
                end
            end
            PH_WR_PULSE: begin
                if (core_q.cnt != '0) begin
                    core_d.cnt = core_q.cnt - 1'b1;
                end else begin
                    core_d.phase = PH_WR_HOLD;
                    core_d.cnt   = LD_HOLD;
                end
            end
            PH_WR_HOLD: begin
                if (core_q.cnt != '0) begin
                    core_d.cnt = core_q.cnt - 1'b1;
                end else begin
                    core_d.phase = PH_IDLE;
                end
            end
            PH_RD_WAIT: begin
                if (lane_quiet[0]) begin
                    core_d.phase = PH_RD_ACCESS;
                    core_d.cnt   = LD_ACCESS;
                end
            end
            PH_RD_ACCESS: begin
                if (core_q.cnt != '0) begin
                    core_d.cnt = core_q.cnt - 1'b1;
                end else begin
                    core_d.rdata  = mem_dq_in;
                    core_d.rvalid = 1'b1;
                    core_d.phase  = PH_IDLE;
                end
            end
            default: core_d.phase = PH_IDLE;
        endcase
    end

    // Strobes are decoded from the next phase and registered, so pins never glitch
    phase_strobe_map u_map (
        .phase (core_d.phase),
        .strb  (strb_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '{phase: PH_IDLE, default: '0};
            strb_q <= STROBE_IDLE;
        end else begin
            core_q <= core_d;
            strb_q <= strb_d;
        end
    end

    assign busy        = (core_q.phase != PH_IDLE);
    assign rdata       = core_q.rdata;
    assign rdata_valid = core_q.rvalid;
    assign mem_addr    = core_q.addr;
    assign mem_dq_out  = core_q.wdata;
    assign mem_sel_n   = strb_q.sel_n;
    assign mem_we_n    = strb_q.we_n;
    assign mem_oe_n    = strb_q.oe_n;
    assign mem_dq_oe   = strb_q.drv;

    // R8: idle means every strobe released and the driver off
    a_r8_idle_released: assert property (@(posedge clk) disable iff (rst)
        (!busy || mem_sel_n) |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

    // R3: write enable only under select, never with output enable
    a_r3_we_under_sel: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_sel_n && mem_oe_n));

    // R4: byte driven across the whole pulse
    a_r4_data_in_pulse: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_oe);

    // R4: hold after the terminating edge
    a_r4_hold_after_we: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_sel_n && $stable(mem_addr) && $stable(mem_dq_out)));

    // R6: valid flag lasts one cycle
    a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |=> !rdata_valid);

    // R7: no contention between driver and memory output
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_oe_n));

    // R7: output enable falls only after the driver has been quiet
    a_r7_oe_after_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> lane_quiet[0]);

    // R7: driver starts only after output enable has been quiet
    a_r7_drv_after_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> lane_quiet[1]);

    // R9: address still while select stays low
    a_r9_addr_still: assert property (@(posedge clk) disable iff (rst)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

endmodule

// File: tb/tb_sram_strobe_ctrl.sv
module tb_sram_strobe_ctrl;

    localparam int AW = 21;
    localparam int DW = 8;
    localparam int SETUP_CYC  = 1;
    localparam int PULSE_CYC  = 7;
    localparam int HOLD_CYC   = 1;
    localparam int ACCESS_CYC = 7;
    localparam int TURN_CYC   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic busy, rdata_valid;
    logic [DW-1:0] rdata;
    logic [AW-1:0] mem_addr;
    logic mem_sel_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    sram_strobe_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC(HOLD_CYC), .ACCESS_CYC(ACCESS_CYC), .TURN_CYC(TURN_CYC)
    ) dut (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .rdata(rdata), .rdata_valid(rdata_valid),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fill_val(logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A;
    endfunction

    // ---------------- behavioural memory with timing monitor ----------------
    logic [DW-1:0] cells [logic [AW-1:0]];
    logic [DW-1:0] sb    [logic [AW-1:0]];
    int sel_low_n = 0, we_low_n = 0, oe_low_n = 0, drv_off_n = 100, oe_high_n = 100;
    logic p_sel = 1'b1, p_we = 1'b1, p_oe = 1'b1, p_drv = 1'b0;
    logic [AW-1:0] p_addr = '0;

    function automatic logic [DW-1:0] cell_rd(logic [AW-1:0] a);
        if (cells.exists(a)) return cells[a];
        return fill_val(a);
    endfunction

    always_comb begin
        if (!mem_sel_n && !mem_oe_n && mem_we_n && oe_low_n >= ACCESS_CYC)
            mem_dq_in = cell_rd(mem_addr);
        else
            mem_dq_in = 8'hEE;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe && !mem_oe_n) chk(0, "R7 driver overlaps output enable", 1, 0);
            if (mem_sel_n && (!mem_we_n || !mem_oe_n || mem_dq_oe))
                chk(0, "R8 strobe active while deselected", 1, 0);
            if (!mem_we_n && !mem_dq_oe) chk(0, "R4 data not driven in pulse", 0, 1);
            if (!mem_sel_n && !p_sel && mem_addr != p_addr)
                chk(0, "R9 address moved under select", int'(mem_addr), int'(p_addr));
            if (!mem_we_n && p_we) begin
                chk(sel_low_n >= SETUP_CYC, "R3 select-to-write setup", sel_low_n, SETUP_CYC);
                chk(mem_oe_n, "R3 output enable high in write", int'(mem_oe_n), 1);
            end
            if (mem_we_n && !p_we) begin
                chk(we_low_n == PULSE_CYC, "R3 write pulse width", we_low_n, PULSE_CYC);
                chk(mem_dq_oe && !mem_sel_n && mem_addr == p_addr, "R4 hold after write end",
                    int'(mem_dq_oe), 1);
                cells[mem_addr] = mem_dq_out;
            end
            if (!mem_oe_n && p_oe)
                chk(drv_off_n >= TURN_CYC, "R7 driver quiet before output enable", drv_off_n, TURN_CYC);
            if (mem_oe_n && !p_oe)
                chk(oe_low_n == ACCESS_CYC, "R5 output enable width", oe_low_n, ACCESS_CYC);
            if (mem_dq_oe && !p_drv)
                chk(oe_high_n >= TURN_CYC, "R7 output enable quiet before drive", oe_high_n, TURN_CYC);
            sel_low_n = mem_sel_n ? 0 : sel_low_n + 1;
            we_low_n  = mem_we_n  ? 0 : we_low_n + 1;
            oe_low_n  = mem_oe_n  ? 0 : oe_low_n + 1;
            drv_off_n = mem_dq_oe ? 0 : (drv_off_n < 100 ? drv_off_n + 1 : 100);
            oe_high_n = !mem_oe_n ? 0 : (oe_high_n < 100 ? oe_high_n + 1 : 100);
            p_sel = mem_sel_n; p_we = mem_we_n; p_oe = mem_oe_n; p_drv = mem_dq_oe;
            p_addr = mem_addr;
        end
    end

    // ---------------- host tasks ----------------
    task automatic host_write(logic [AW-1:0] a, logic [DW-1:0] d, int stray, output int blen);
        @(negedge clk);
        while (busy) @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        sb[a] = d;
        @(negedge clk);
        blen = 0;
        if (stray > 0) begin
            req_addr = a ^ 21'h0000FF; req_wdata = ~d;   // ignored while busy (R2)
        end else begin
            req = 1'b0;
        end
        while (busy) begin
            blen++;
            if (blen >= stray) req = 1'b0;
            @(negedge clk);
        end
        req = 1'b0;
    endtask

    task automatic host_read(logic [AW-1:0] a, output int blen);
        logic [DW-1:0] exp;
        exp = sb.exists(a) ? sb[a] : fill_val(a);
        @(negedge clk);
        while (busy) @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = a;
        @(negedge clk);
        req = 1'b0;
        blen = 0;
        while (busy) begin
            blen++;
            chk(!rdata_valid, "R6 valid early", int'(rdata_valid), 0);
            @(negedge clk);
        end
        chk(rdata_valid, "R6 valid when busy drops", int'(rdata_valid), 1);
        chk(rdata == exp, "R5 read data", int'(rdata), int'(exp));
        @(negedge clk);
        chk(!rdata_valid, "R6 valid lasts one cycle", int'(rdata_valid), 0);
    endtask

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int blen;
        logic [AW-1:0] a;
        repeat (3) @(negedge clk);
        chk(mem_sel_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !rdata_valid,
            "R1 outputs during reset", 0, 1);
        rst = 1'b0;
        idle_cycles(3);
        chk(mem_sel_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !rdata_valid,
            "R1 outputs after reset", 0, 1);

        // Isolated write with a stray request held while busy (R2)
        host_write(21'h000155, 8'h3C, 6, blen);
        chk(blen == SETUP_CYC + PULSE_CYC + HOLD_CYC, "R2 write busy length", blen,
            SETUP_CYC + PULSE_CYC + HOLD_CYC);
        chk(mem_sel_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R8 released after write", 0, 1);
        idle_cycles(5);
        host_read(21'h000155 ^ 21'h0000FF, blen);   // stray address keeps its fill value
        chk(blen == 1 + ACCESS_CYC, "R2 read busy length", blen, 1 + ACCESS_CYC);
        host_read(21'h000155, blen);

        // Walking-one address sweep, data computed from the index
        for (int i = 0; i < AW; i++) begin
            a = AW'(1) << i;
            host_write(a, DW'(i * 37 + 11), 0, blen);
        end
        for (int i = 0; i < AW; i++) begin
            a = AW'(1) << i;
            host_read(a, blen);
        end
        host_read('0, blen);
        host_read('1, blen);

        // Back-to-back write then read, exercising turnaround (R7)
        for (int i = 0; i < 24; i++) begin
            a = AW'(i * 4099 + 7);
            host_write(a, DW'(8'hA5 ^ i), 0, blen);
            host_read(a, blen);
        end
        // Read then write then read on neighbouring cells
        for (int i = 0; i < 8; i++) begin
            a = AW'(21'h1F0000 + i);
            host_read(a, blen);
            host_write(a, DW'(i * 29), 0, blen);
            host_read(a, blen);
        end
        idle_cycles(4);
        chk(mem_sel_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy, "R8 idle at end", 0, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule